// File: doc/BRIEF.md
# Four-Bit Ripple Magnitude Comparator

This block compares two 4-bit unsigned operands. It uses a chain of four identical one-bit cells. The cell holding the most significant bit starts the chain. It is seeded with the status "equal so far, not yet greater". Each cell looks at its own bit of each operand and at the status handed down from the cell above it. It then passes an updated status to the cell below.

The cell holding bit 0 produces the word-level result. If its greater flag is high, operand A exceeds operand B. If its equal flag is high, the two operands match. If both flags are low, A is below B.

The block is purely combinational: it has no clock and no reset. A greater-or-equal output is also provided; it is the OR of the two final flags.

Top module: `mag_cmp4`

## Requirements
- R1: Each cell drives its greater flag high when the incoming greater flag is high, or when the incoming equal flag is high and the cell's A bit is 1 and its B bit is 0. Otherwise the greater flag is low.
- R2: Each cell drives its equal flag high only when the incoming equal flag is high and the cell's two operand bits match.
- R3: A cell whose incoming flags are not both high never drives both outgoing flags high.
- R4: The bit-3 cell is seeded with equal = 1 and greater = 0, and status flows from bit 3 down to bit 0. As a result, the most significant differing bit alone decides the result.
- R5: `a_gt_b` is high exactly when A > B as unsigned numbers, for all 256 operand pairs.
- R6: `a_eq_b` is high exactly when A == B, for all 256 operand pairs.
- R7: `a_gt_b` and `a_eq_b` are never both high. Both low encodes A < B.
- R8: `a_ge_b` is high exactly when A >= B, for all 256 operand pairs.
- R9: The outputs follow an operand change within the same time step, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 4 | Unsigned operand A |
| op_b | input | 4 | Unsigned operand B |
| a_gt_b | output | 1 | High when A is greater than B |
| a_eq_b | output | 1 | High when A equals B |
| a_ge_b | output | 1 | High when A is greater than or equal to B |

## Verification
Some properties are checked by the assertions whenever the inputs settle:
- each cell keeps a greater verdict it received from upstream;
- each cell asserts equal only if equal arrived from above;
- a cell with legal inputs never raises both flags;
- the word outputs never raise both flags;
- the word outputs agree with a plain numeric comparison.

The bench's scenarios cover what those assertions cannot show. One scenario sweeps all sixteen input combinations of a lone cell, including the illegal one. Another sweeps all 256 operand pairs. Directed corner pairs show that the highest differing bit wins. A timing check shows that the outputs respond without any clock edge.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;
  localparam int unsigned CMP_WIDTH = 4;
  localparam int unsigned CHAIN_LEN = CMP_WIDTH + 1;

  typedef struct packed {
    logic eq;
    logic gt;
  } cmp_status_t;

  localparam cmp_status_t SEED_STATUS = '{eq: 1'b1, gt: 1'b0};

  function automatic logic next_gt(input cmp_status_t up, input logic a_bit, input logic b_bit);
    return up.gt | (up.eq & a_bit & ~b_bit);
  endfunction

  function automatic logic next_eq(input cmp_status_t up, input logic a_bit, input logic b_bit);
    return up.eq & ~(a_bit ^ b_bit);
  endfunction
endpackage

// File: rtl/mag_cmp_slice.sv
module mag_cmp_slice
  import mag_cmp_pkg::*;
(
  input  logic a_bit,
  input  logic b_bit,
  input  logic eq_in,
  input  logic gt_in,
  output logic eq_out,
  output logic gt_out
);
  cmp_status_t up_status;
  logic        bits_differ;
  logic        a_wins_here;
  logic        legal_in;

  assign up_status   = '{eq: eq_in, gt: gt_in};
  assign bits_differ = a_bit ^ b_bit;
  assign a_wins_here = a_bit & ~b_bit;
  assign legal_in    = ~(eq_in & gt_in);

  assign gt_out = next_gt(up_status, a_bit, b_bit);
  assign eq_out = next_eq(up_status, a_bit, b_bit);

  always_comb begin
    if (!$isunknown({a_bit, b_bit, eq_in, gt_in, eq_out, gt_out})) begin
      // R1: an upstream greater verdict is never lost
      assert_keep_greater_R1: assert (!gt_in || gt_out);
      // R2: equality can only survive, never be created
      assert_eq_needs_upstream_R2: assert (!eq_out || (eq_in && !bits_differ));
      // R3: legal inputs never give both flags
      assert_no_double_flag_R3: assert (!legal_in || !(eq_out && gt_out));
    end
  end
endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
  import mag_cmp_pkg::*;
#(
  parameter int unsigned WIDTH = CMP_WIDTH
) (
  input  logic [WIDTH-1:0] a_word,
  input  logic [WIDTH-1:0] b_word,
  output logic             final_eq,
  output logic             final_gt
);
  localparam int unsigned LINKS = WIDTH + 1;

  logic [LINKS-1:0] eq_link;
  logic [LINKS-1:0] gt_link;

  // R4: seed enters above the most significant slice
  assign eq_link[WIDTH] = SEED_STATUS.eq;
  assign gt_link[WIDTH] = SEED_STATUS.gt;

  for (genvar i = WIDTH - 1; i >= 0; i--) begin : g_slice
    mag_cmp_slice u_slice (
      .a_bit (a_word[i]),
      .b_bit (b_word[i]),
      .eq_in (eq_link[i+1]),
      .gt_in (gt_link[i+1]),
      .eq_out(eq_link[i]),
      .gt_out(gt_link[i])
    );
  end

  assign final_eq = eq_link[0];
  assign final_gt = gt_link[0];
endmodule

// File: rtl/mag_cmp4.sv
module mag_cmp4
  import mag_cmp_pkg::*;
(
  input  logic [CMP_WIDTH-1:0] op_a,
  input  logic [CMP_WIDTH-1:0] op_b,
  output logic                 a_gt_b,
  output logic                 a_eq_b,
  output logic                 a_ge_b
);
  logic chain_eq;
  logic chain_gt;

  mag_cmp_chain #(.WIDTH(CMP_WIDTH)) u_chain (
    .a_word  (op_a),
    .b_word  (op_b),
    .final_eq(chain_eq),
    .final_gt(chain_gt)
  );

  assign a_gt_b = chain_gt;
  assign a_eq_b = chain_eq;
  assign a_ge_b = chain_gt | chain_eq;

  always_comb begin
    if (!$isunknown({op_a, op_b, a_gt_b, a_eq_b})) begin
      assert_exclusive_flags_R7: assert ($onehot0({a_gt_b, a_eq_b}));
      assert_gt_matches_R5: assert (a_gt_b == (op_a > op_b));
      assert_eq_matches_R6: assert (a_eq_b == (op_a == op_b));
      assert_ge_matches_R8: assert (a_ge_b == (op_a >= op_b));
    end
  end
endmodule

// File: tb/mag_cmp4_test.sv
`timescale 1ns/1ps
module mag_cmp4_test;
  logic       clk = 1'b0;
  logic [3:0] op_a = 4'd0;
  logic [3:0] op_b = 4'd0;
  logic       a_gt_b, a_eq_b, a_ge_b;
  logic       s_a = 1'b0, s_b = 1'b0, s_ei = 1'b0, s_gi = 1'b0;
  logic       s_eo, s_go;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  mag_cmp4 uut (.op_a(op_a), .op_b(op_b), .a_gt_b(a_gt_b), .a_eq_b(a_eq_b), .a_ge_b(a_ge_b));
  mag_cmp_slice slice_uut (.a_bit(s_a), .b_bit(s_b), .eq_in(s_ei), .gt_in(s_gi),
                           .eq_out(s_eo), .gt_out(s_go));

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b (a=%0d b=%0d)", req, what, act, exp, op_a, op_b);
    end
  endtask

  task automatic check_word(input string req);
    int ia = int'(op_a);
    int ib = int'(op_b);
    check(req, a_gt_b, (ia - ib) > 0, "gt");
    check(req, a_eq_b, (ia - ib) == 0, "eq");
    check(req, a_ge_b, !((ia - ib) < 0), "ge");
    check("R7", a_gt_b & a_eq_b, 1'b0, "both flags");
  endtask

  task automatic apply(input int a, input int b);
    @(negedge clk);
    op_a = 4'(a);
    op_b = 4'(b);
    #1;
  endtask

  task automatic test_initial_state;
    #1;
    check("R6", a_eq_b, 1'b1, "initial eq at 0,0");
    check("R5", a_gt_b, 1'b0, "initial gt at 0,0");
    check("R8", a_ge_b, 1'b1, "initial ge at 0,0");
  endtask

  task automatic test_slice_sweep;
    for (int v = 0; v < 16; v++) begin
      logic exp_gt, exp_eq;
      @(negedge clk);
      {s_ei, s_gi, s_a, s_b} = 4'(v);
      #1;
      if (s_gi) exp_gt = 1'b1;
      else if (s_ei) exp_gt = (s_a == 1'b1) && (s_b == 1'b0);
      else exp_gt = 1'b0;
      exp_eq = s_ei && (s_a == s_b);
      check("R1", s_go, exp_gt, "slice gt");
      check("R2", s_eo, exp_eq, "slice eq");
      if (!(s_ei && s_gi)) check("R3", s_go & s_eo, 1'b0, "slice both flags");
    end
  endtask

  task automatic test_full_sweep;
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        apply(a, b);
        check_word("R5");
        check_word("R6");
        check_word("R8");
      end
    end
  endtask

  task automatic test_msb_priority;
    apply(8, 7);   check("R4", a_gt_b, 1'b1, "msb 8 vs 7");
    apply(7, 8);   check("R4", a_gt_b | a_eq_b, 1'b0, "msb 7 vs 8 is less");
    apply(15, 0);  check("R4", a_gt_b, 1'b1, "15 vs 0");
    apply(0, 15);  check("R4", a_ge_b, 1'b0, "0 vs 15");
    apply(9, 14);  check("R4", a_gt_b, 1'b0, "9 vs 14");
    apply(14, 9);  check("R4", a_gt_b, 1'b1, "14 vs 9");
    apply(15, 15); check("R4", a_eq_b, 1'b1, "15 vs 15");
  endtask

  task automatic test_no_clock_response;
    @(negedge clk);
    op_a = 4'd3; op_b = 4'd5;
    #0.5;
    check("R9", a_gt_b | a_eq_b, 1'b0, "3 vs 5 without edge");
    op_a = 4'd6;
    #0.5;
    check("R9", a_gt_b, 1'b1, "6 vs 5 without edge");
    op_b = 4'd6;
    #0.5;
    check("R9", a_eq_b, 1'b1, "6 vs 6 without edge");
  endtask

  initial begin
    test_initial_state();
    test_slice_sweep();
    test_full_sweep();
    test_msb_priority();
    test_no_clock_response();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule